// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter that advances on a low-speed tick enable (nominally 32.768 kHz) and that software cannot stop once the block is out of reset. Software must clear it with a two-write key sequence before the count reaches the selected period. If the period runs out once, the block raises a one-cycle non-maskable interrupt request, which gives the handler a last chance to recover. If the period runs out a second time with no valid clear in between, the block raises a system reset request. That request stays high until the block itself is reset.

Software reaches the block through a single write port. A select bit chooses one of two targets: the key register or the period register. The 2-bit period code picks 2^(BASE_LOG2 + 2*code) ticks. With the default BASE_LOG2 of 12, that gives 4096, 16384, 65536 or 262144 ticks, which is 125 ms, 500 ms, 2 s or 8 s at 32.768 kHz. A newly written code waits in a pending register and takes over only at the next valid clear.

Top module: `wdt_twostage`

## Requirements
- R1: After a synchronous reset, `nmi_pulse` and `rst_req` are 0, the count is zero, and both the pending and the active period code are 0.
- R2: After a clear or a reset, an overflow occurs on the 2^(BASE_LOG2 + 2*code)-th cycle with `tick_en` high. The output it causes is visible in the cycle after that tick's clock edge.
- R3: An overflow in the clean stage produces a `nmi_pulse` exactly one cycle long, moves the block to the warned stage, and does not raise `rst_req`.
- R4: An overflow in the warned stage raises `rst_req`. Once high, `rst_req` stays high until `rst`, and no clear can lower it.
- R5: A valid clear zeroes the count and returns the stage to clean. A valid clear is a write with `wr_sel`=0 and `wr_data`=0x5A, followed by the next `wr_sel`=0 write carrying 0xA5. Writes with `wr_sel`=1 in between do not break the sequence.
- R6: Any `wr_sel`=0 write other than 0x5A or 0xA5 disarms the key. A lone 0xA5 has no effect. A repeated 0x5A leaves the key armed.
- R7: A write with `wr_sel`=1 stores `wr_data[1:0]` as the pending period code. That code becomes the active period only at the next valid clear.
- R8: The block has no stop control. With `tick_en` high, the count advances on every cycle except a clearing one, whatever is written.
- R9: A clear while the block is in the warned stage cancels it, so the next overflow gives a `nmi_pulse` again and not `rst_req`.
- R10: When a valid clear and an overflowing tick fall in the same cycle, the clear wins: no `nmi_pulse`, no `rst_req`, and the count restarts from zero.
- R11: The count holds while `tick_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Low-speed tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = key register, 1 = period register |
| wr_data | input | 8 | Write data |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A wrong count or a wrong active period shows up at the ports as an interrupt that comes early or late. This appears within one period of the last clear, so the bench compares every cycle against a tick-accurate model. A wrong stage bit shows up only at the next overflow, where a reset request appears in place of an interrupt, or the reverse. For this reason the directed tests deliberately run through two overflows, clear between them, and collide a clear with an overflowing tick. A corrupted key sequence or pending period stays invisible until an overflow comes early or late, so the random phase mixes key values with period writes over long stretches.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h5A;
    localparam logic [7:0] KEY_FIRE = 8'hA5;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
    typedef enum logic {STG_CLEAN, STG_WARNED} stage_e;

    typedef struct packed {
        logic       wr;
        logic [1:0] code;
    } period_wr_t;

    function automatic int unsigned period_exp(int unsigned base_log2, logic [1:0] code);
        return base_log2 + 2 * int'(code);
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       clr_o
);
    key_state_e state_q;
    logic       key_wr;

    assign key_wr = wr_en && !wr_sel;
    assign clr_o  = key_wr && (state_q == KEY_ARMED) && (wr_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KEY_IDLE;
        end else if (key_wr) begin
            state_q <= (wr_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
        end
    end

    // R6: an armed key is left only by a key write
    assert_arm_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == KEY_ARMED && !key_wr) |=> state_q == KEY_ARMED);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int CW        = BASE_LOG2 + 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       clr_i,
    input  period_wr_t pwr_i,
    output logic       ovf_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic [1:0]    pend_q;
    logic [1:0]    act_q;

    always_comb begin
        limit = (CW'(1) << period_exp(BASE_LOG2, act_q)) - CW'(1);
    end

    assign ovf_o = tick_i && !clr_i && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 2'd0;
        end else if (pwr_i.wr) begin
            pend_q <= pwr_i.code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 2'd0;
        end else if (clr_i) begin
            cnt_q <= '0;
            act_q <= pend_q;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CW'(1);
        end
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit);

    assert_never_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !clr_i) |=> cnt_q != $past(cnt_q));

    assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

    // R7: the active period moves only on a clear
    assert_period_deferred_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> $stable(act_q));

endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovf_i,
    input  logic clr_i,
    output logic nmi_o,
    output logic rst_req_o
);
    stage_e stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= STG_CLEAN;
            nmi_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            nmi_o <= 1'b0;
            if (clr_i) begin
                stage_q <= STG_CLEAN;
            end else if (ovf_i) begin
                if (stage_q == STG_CLEAN) begin
                    stage_q <= STG_WARNED;
                    nmi_o   <= 1'b1;
                end else begin
                    rst_req_o <= 1'b1;
                end
            end
        end
    end

    assert_nmi_single_R3: assert property (@(posedge clk) disable iff (rst)
        nmi_o |=> !nmi_o);

    assert_reset_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o);

    assert_reset_needs_warn_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> $past(stage_q == STG_WARNED));

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!nmi_o && $stable(rst_req_o)));

endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       nmi_pulse,
    output logic       rst_req
);
    localparam int CW = BASE_LOG2 + 6;

    logic       clr;
    logic       ovf;
    period_wr_t pwr;

    assign pwr.wr   = wr_en && wr_sel;
    assign pwr.code = wr_data[1:0];

    wdt_key_seq u_key (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .clr_o   (clr)
    );

    wdt_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .CW        (CW)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_en),
        .clr_i  (clr),
        .pwr_i  (pwr),
        .ovf_o  (ovf)
    );

    wdt_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .ovf_i     (ovf),
        .clr_i     (clr),
        .nmi_o     (nmi_pulse),
        .rst_req_o (rst_req)
    );

    // R1: no request can be produced without a prior overflow
    assert_nmi_from_ovf_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_pulse) |-> $past(ovf));

endmodule

// File: tb/wdt_twostage_tb_top.sv
module wdt_twostage_tb_top;
    localparam int B = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       nmi_pulse;
    logic       rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    int   m_cnt;
    bit   m_warn, m_rst, m_arm, m_nmi;
    logic [1:0] m_pend, m_act;

    always #10 clk = ~clk;

    wdt_twostage #(.BASE_LOG2(B)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .nmi_pulse(nmi_pulse), .rst_req(rst_req)
    );

    function automatic int period_ticks(logic [1:0] code);
        return 1 << (B + 2 * int'(code));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_warn = 0; m_rst = 0; m_arm = 0; m_nmi = 0;
        m_pend = 2'd0; m_act = 2'd0;
    endtask

    task automatic model_step(bit t, bit we, bit sel, logic [7:0] d);
        bit fire;
        fire = we && !sel && m_arm && (d == 8'hA5);
        m_nmi = 0;
        if (we && !sel) m_arm = (d == 8'h5A);
        if (we && sel) m_pend = d[1:0];
        if (fire) begin
            m_cnt = 0; m_warn = 0; m_act = m_pend;
        end else if (t) begin
            if (m_cnt == period_ticks(m_act) - 1) begin
                m_cnt = 0;
                if (!m_warn) begin m_warn = 1; m_nmi = 1; end
                else m_rst = 1;
            end else m_cnt++;
        end
    endtask

    task automatic step(bit t, bit we, bit sel, logic [7:0] d, string req);
        @(negedge clk);
        tick_en = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        model_step(t, we, sel, d);
        #1;
        check(nmi_pulse == m_nmi, req, "nmi_pulse", int'(nmi_pulse), int'(m_nmi));
        check(rst_req == m_rst, req, "rst_req", int'(rst_req), int'(m_rst));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tick_en = 0; wr_en = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic key_clear(string req);
        step(0, 1, 0, 8'h5A, req);
        step(0, 1, 0, 8'hA5, req);
    endtask

    task automatic ticks(int n, string req);
        for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, req);
    endtask

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        check(nmi_pulse == 0 && rst_req == 0, "R1", "outputs after reset",
              int'({nmi_pulse, rst_req}), 0);
        step(0, 0, 0, 8'h00, "R1");

        // R2 R3: first overflow on the 16th tick
        for (int i = 1; i <= period_ticks(2'd0); i++) begin
            step(1, 0, 0, 8'h00, "R2");
            check(nmi_pulse == (i == period_ticks(2'd0)), "R3", "nmi timing",
                  int'(nmi_pulse), int'(i == period_ticks(2'd0)));
        end
        // R4: second overflow raises reset request, sticky through clears
        ticks(period_ticks(2'd0), "R4");
        check(rst_req == 1, "R4", "reset request", int'(rst_req), 1);
        key_clear("R4");
        ticks(5, "R4");
        check(rst_req == 1, "R4", "sticky reset request", int'(rst_req), 1);

        // R7: pending period deferred until clear
        do_reset();
        step(0, 1, 1, 8'h02, "R7");
        ticks(period_ticks(2'd0), "R7");
        key_clear("R7");
        for (int i = 1; i <= period_ticks(2'd2); i++) begin
            step(1, 0, 0, 8'h00, "R7");
            if (i == period_ticks(2'd0) || i == period_ticks(2'd2))
                check(nmi_pulse == (i == period_ticks(2'd2)), "R7", "deferred period",
                      int'(nmi_pulse), int'(i == period_ticks(2'd2)));
        end

        // R6: bad key sequences have no effect; repeated 0x5A stays armed
        do_reset();
        ticks(10, "R6");
        step(0, 1, 0, 8'hA5, "R6");
        step(0, 1, 0, 8'h5A, "R6");
        step(0, 1, 0, 8'h33, "R6");
        step(0, 1, 0, 8'hA5, "R6");
        ticks(6, "R6");
        check(nmi_pulse == 1, "R6", "ignored key, nmi on schedule", int'(nmi_pulse), 1);
        step(0, 1, 0, 8'h5A, "R6");
        step(0, 1, 0, 8'h5A, "R6");
        step(0, 1, 0, 8'hA5, "R6");
        // R9: clear after warning; next overflow is nmi again
        ticks(period_ticks(2'd0), "R9");
        check(nmi_pulse == 1 && rst_req == 0, "R9", "nmi after cancelled warning",
              int'({nmi_pulse, rst_req}), 2);

        // R5: period-register write inside the key sequence does not break it
        step(0, 1, 0, 8'h5A, "R5");
        step(0, 1, 1, 8'h00, "R5");
        step(0, 1, 0, 8'hA5, "R5");
        ticks(period_ticks(2'd0), "R5");
        check(rst_req == 0 && nmi_pulse == 1, "R5", "clear with interleaved write",
              int'({nmi_pulse, rst_req}), 2);

        // R10: clear collides with the overflowing tick
        step(0, 1, 0, 8'h5A, "R10");
        ticks(period_ticks(2'd0) - 1, "R10");
        step(1, 1, 0, 8'hA5, "R10");
        check(nmi_pulse == 0 && rst_req == 0, "R10", "clear beats overflow",
              int'({nmi_pulse, rst_req}), 0);
        ticks(period_ticks(2'd0), "R10");
        check(nmi_pulse == 1, "R10", "restart from zero", int'(nmi_pulse), 1);

        // R8 R11: random ticks and writes against the model
        void'($urandom(32'd20240517));
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int i = 0; i < 3000; i++) begin
                bit t, we, sel;
                logic [7:0] d;
                int k;
                t   = ($urandom % 3) != 0;
                we  = ($urandom % 10) == 0;
                sel = ($urandom % 4) == 0;
                k   = $urandom % 4;
                d   = (k == 0) ? 8'h5A : (k == 1) ? 8'hA5 : 8'($urandom);
                step(t, we, sel, d, (i % 2) ? "R8" : "R11");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule